// File: doc/BRIEF.md
# Nested priority interrupt controller

The controller gathers interrupt requests from a fixed set of peripheral sources and records each one in a pending flag. Each source is either edge type or level type, and this is fixed by a parameter. A flag is recorded whether or not its source is enabled. Pending flags are qualified by a per-source enable bit and a global enable bit. The controller then offers the CPU the most urgent qualified source as a request strobe and a 5-bit vector index.

Each source is given one of four priority levels through a register. When two sources share a level, the lower source index wins. An acknowledge input accepts the offered vector. Accepting a vector marks that source's priority level as in service. From then on, only a strictly higher level can raise a new request. A return pulse retires the highest in-service level, and the pending requests are then weighed again against the level below it. A parameter mask selects the sources whose flag is cleared by hardware on acknowledge. Software must clear the flags of all other sources through a write-one-to-clear register.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, all of the following read as zero: the enable register (address 0), the flag register (address 1), the priority register (address 2) and the control register (address 3). The request output is low.
- R2: An edge-type source sets its flag on a rising edge of its input, even while the source or the global enable is off. Flag bit i at address 1 reads the flag of source i.
- R3: An edge-type source whose input stays high after its flag is cleared does not set the flag again.
- R4: A level-type source sets its flag on every cycle its input is high. A software clear only takes effect once the input has dropped.
- R5: A request is raised one cycle after a qualified flag, or the enable that qualifies it, is registered. The request drops in the cycle after an acknowledge.
- R6: A flag raises no request unless its enable bit (bit i at address 0) and the global enable (bit 0 at address 3) are both set.
- R7: Among qualified flags, the highest priority level wins. The priority level of source i is bits 2i+1:2i at address 2, and 3 is the most urgent. Within a level, the lowest source index wins. The vector index equals the source index.
- R8: While a level is in service, only a qualified flag of a strictly higher level raises a request. The in-service mask reads at bits 11:8 of address 3, with bit 8+L standing for level L. An equal or lower level stays pending.
- R9: A return pulse clears the highest set in-service bit. Pending requests are then judged against the next lower level, or raise freely once the mask is empty.
- R10: On acknowledge, the flag of a hardware-cleared source is cleared. The flag of any other source stays set.
- R11: Writing ones to address 1 clears those flags, several at once. A new edge that arrives in the same cycle as the clear wins, and the flag stays set.
- R12: While the request is high and no acknowledge arrives, the request stays high and the vector index does not change.
- R13: Enable bits above the source count and control bits other than bit 0 ignore writes and read zero. The in-service mask is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Peripheral interrupt inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| ack_i | input | 1 | CPU accepts the offered vector |
| ret_i | input | 1 | Return-from-interrupt pulse |
| req_o | output | 1 | Interrupt request strobe |
| vec_o | output | 5 | Vector index of the offered source |

## Verification
A corrupted in-service mask shows up in one of two ways one cycle after the next evaluation. An equal-level source gets through as a request, or a higher-level source is blocked. The mask bits in the control register show the damage directly after each acknowledge or return. A wrong flag update shows at the flag register in the same cycle it happens. Examples are a lost edge during a clear, a level source that lets go too early, or a hardware clear on the wrong source. A flag that never clears leaves the request stuck high one cycle after the handler returns. A broken hold of the request shows as a vector index that moves before the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W  = 32;
  localparam int PRIO_W  = 2;
  localparam int NUM_LVL = 1 << PRIO_W;
  localparam int VEC_W   = 5;
  localparam int SVC_LSB = 8;

  typedef enum logic [1:0] {
    ADDR_EN   = 2'd0,
    ADDR_FLAG = 2'd1,
    ADDR_PRIO = 2'd2,
    ADDR_CTL  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int          N_SRC       = 16,
  parameter logic [15:0] LEVEL_MASK  = 16'h0030,
  parameter logic [15:0] HW_CLR_MASK = 16'h0F0F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] flags_o,
  output logic [N_SRC-1:0] src_q_o
);
  logic [N_SRC-1:0] src_q, flags_q, set_w, hw_clr_w;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign set_w[i] = src_i[i];
    end else begin : g_edge
      assign set_w[i] = src_i[i] & ~src_q[i];
    end
    if (HW_CLR_MASK[i]) begin : g_hwclr
      assign hw_clr_w[i] = ack_clr_i[i];
    end else begin : g_swclr
      assign hw_clr_w[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      flags_q <= '0;
    end else begin
      src_q   <= src_i;
      // set wins over any clear in the same cycle
      flags_q <= (flags_q & ~sw_clr_i & ~hw_clr_w) | set_w;
    end
  end

  assign flags_o = flags_q;
  assign src_q_o = src_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [1:0]              addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [N_SRC-1:0]        flags_i,
  input  logic [NUM_LVL-1:0]      svc_i,
  output logic [N_SRC-1:0]        en_o,
  output logic [N_SRC*PRIO_W-1:0] prio_o,
  output logic                    gie_o,
  output logic [N_SRC-1:0]        sw_clr_o,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam int PRIO_BITS = N_SRC * PRIO_W;

  logic [N_SRC-1:0]     en_q;
  logic [PRIO_BITS-1:0] prio_q;
  logic                 gie_q;
  reg_addr_e            addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
      gie_q  <= 1'b0;
    end else if (we_i) begin
      case (addr)
        ADDR_EN:   en_q   <= wdata_i[N_SRC-1:0];
        ADDR_PRIO: prio_q <= wdata_i[PRIO_BITS-1:0];
        ADDR_CTL:  gie_q  <= wdata_i[0];
        default:   ;
      endcase
    end
  end

  assign sw_clr_o = (we_i && addr == ADDR_FLAG) ? wdata_i[N_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr)
      ADDR_EN:   rdata_o[N_SRC-1:0]     = en_q;
      ADDR_FLAG: rdata_o[N_SRC-1:0]     = flags_i;
      ADDR_PRIO: rdata_o[PRIO_BITS-1:0] = prio_q;
      ADDR_CTL: begin
        rdata_o[0]                 = gie_q;
        rdata_o[SVC_LSB +: NUM_LVL] = svc_i;
      end
      default:   ;
    endcase
  end

  assign en_o   = en_q;
  assign prio_o = prio_q;
  assign gie_o  = gie_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic [N_SRC-1:0]        elig_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    valid_o,
  output logic [VEC_W-1:0]        idx_o,
  output logic [PRIO_W-1:0]       lvl_o
);
  // levels scanned high to low, indices low to high: first hit wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (!valid_o && elig_i[i] && prio_i[i*PRIO_W +: PRIO_W] == PRIO_W'(l)) begin
          valid_o = 1'b1;
          idx_o   = VEC_W'(i);
          lvl_o   = PRIO_W'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [PRIO_W-1:0]  push_lvl_i,
  input  logic               pop_i,
  output logic [NUM_LVL-1:0] svc_o,
  output logic               cur_valid_o,
  output logic [PRIO_W-1:0]  cur_lvl_o
);
  logic [NUM_LVL-1:0] svc_q, top_bit, push_bit;

  always_comb begin
    cur_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (svc_q[l]) cur_lvl_o = PRIO_W'(l);
    end
  end

  assign cur_valid_o = |svc_q;
  assign top_bit     = cur_valid_o ? (NUM_LVL'(1) << cur_lvl_o) : '0;
  assign push_bit    = push_i ? (NUM_LVL'(1) << push_lvl_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= '0;
    else         svc_q <= (pop_i ? (svc_q & ~top_bit) : svc_q) | push_bit;
  end

  assign svc_o = svc_q;
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import irq_pkg::*;
#(
  parameter int          N_SRC       = 16,
  parameter logic [15:0] LEVEL_MASK  = 16'h0030,
  parameter logic [15:0] HW_CLR_MASK = 16'h0F0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [N_SRC-1:0]        flags, src_q, en, sw_clr, ack_clr, elig;
  logic [N_SRC*PRIO_W-1:0] prio;
  logic                    gie;
  logic [NUM_LVL-1:0]      svc;
  logic                    cur_valid, cand_valid, preempt, take;
  logic [PRIO_W-1:0]       cur_lvl, cand_lvl, lvl_q;
  logic [VEC_W-1:0]        cand_idx, vec_q;
  logic                    req_q;

  assign take    = req_q & ack_i;
  assign ack_clr = take ? (N_SRC'(1) << vec_q) : '0;
  assign elig    = flags & en & {N_SRC{gie}};
  assign preempt = cand_valid & (~cur_valid | (cand_lvl > cur_lvl));

  irq_flag_bank #(
    .N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK), .HW_CLR_MASK(HW_CLR_MASK)
  ) u_flags (
    .clk_i, .rst_ni, .src_i,
    .sw_clr_i(sw_clr), .ack_clr_i(ack_clr),
    .flags_o(flags), .src_q_o(src_q)
  );

  irq_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flags_i(flags), .svc_i(svc),
    .en_o(en), .prio_o(prio), .gie_o(gie),
    .sw_clr_o(sw_clr), .rdata_o(reg_rdata_o)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .elig_i(elig), .prio_i(prio),
    .valid_o(cand_valid), .idx_o(cand_idx), .lvl_o(cand_lvl)
  );

  irq_svc_stack u_svc (
    .clk_i, .rst_ni,
    .push_i(take), .push_lvl_i(lvl_q), .pop_i(ret_i),
    .svc_o(svc), .cur_valid_o(cur_valid), .cur_lvl_o(cur_lvl)
  );

  // offered vector frozen from raise to acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else if (!req_q && preempt) begin
      req_q <= 1'b1;
      vec_q <= cand_idx;
      lvl_q <= cand_lvl;
    end
  end

  assign req_o = req_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int          N_SRC       = 16,
  parameter logic [15:0] LEVEL_MASK  = 16'h0030
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_SRC-1:0]   src_i,
  input logic [N_SRC-1:0]   src_q_i,
  input logic [N_SRC-1:0]   flags_i,
  input logic               gie_i,
  input logic [NUM_LVL-1:0] svc_i,
  input logic               ack_i,
  input logic               ret_i,
  input logic               req_o,
  input logic [VEC_W-1:0]   vec_o
);
  // R12
  hold_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(vec_o));

  // R5
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);

  // R6
  gie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(gie_i));

  // R9
  ret_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !(req_o && ack_i) && (svc_i != '0)
    |=> $countones(svc_i) == $countones($past(svc_i)) - 1);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
    if (LEVEL_MASK[i]) begin : g_lvl
      // R4
      level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_i[i] |=> flags_i[i]);
    end else begin : g_edg
      // R2
      edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_i[i] && !src_q_i[i] |=> flags_i[i]);
    end
  end
endmodule

bind nested_irq_ctrl irq_ctrl_chk #(
  .N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .src_q_i(src_q),
  .flags_i(flags), .gie_i(gie), .svc_i(svc), .ack_i(ack_i),
  .ret_i(ret_i), .req_o(req_o), .vec_o(vec_o)
);

// File: tb/nested_irq_ctrl_bench.sv
module nested_irq_ctrl_bench;
  localparam int N = 16;
  localparam logic [1:0] A_EN = 2'd0, A_FLAG = 2'd1, A_PRIO = 2'd2, A_CTL = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          ack = 1'b0;
  logic          ret = 1'b0;
  logic          req;
  logic [4:0]    vec;

  always #10 clk = ~clk;

  nested_irq_ctrl #(.N_SRC(N), .LEVEL_MASK(16'h0030), .HW_CLR_MASK(16'h0F0F))
  u_nested_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack), .ret_i(ret),
    .req_o(req), .vec_o(vec)
  );

  typedef struct {
    bit          is_req;
    logic [31:0] exp_data;
    logic        exp_req;
    logic [4:0]  exp_vec;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_vec = 0;
  int n_bad = 0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      #1;
      begin
        item_t it;
        it = sb_q.pop_front();
        n_vec++;
        if (it.is_req) begin
          if (req !== it.exp_req || (it.exp_req && vec !== it.exp_vec)) begin
            n_bad++;
            $display("FAIL %s: req=%b vec=%0d expected req=%b vec=%0d",
                     it.tag, req, vec, it.exp_req, it.exp_vec);
          end
        end else if (rdata !== it.exp_data) begin
          n_bad++;
          $display("FAIL %s: rdata=%h expected %h", it.tag, rdata, it.exp_data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
    we = 1'b0;
  endtask

  task automatic exp_rd(logic [1:0] a, logic [31:0] d, string tag);
    item_t it;
    addr = a;
    it.is_req = 1'b0; it.exp_data = d; it.exp_req = 1'b0; it.exp_vec = '0; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic exp_req(logic r, logic [4:0] v, string tag);
    item_t it;
    it.is_req = 1'b1; it.exp_data = '0; it.exp_req = r; it.exp_vec = v; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic pulse(int idx);
    src[idx] = 1'b1;
    cyc();
    src[idx] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; cyc(); ret = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cyc(2);
    rst_n = 1'b1;
    cyc();
    exp_rd(A_EN,   32'h0, "R1 enable reset");
    exp_rd(A_FLAG, 32'h0, "R1 flag reset");
    exp_rd(A_PRIO, 32'h0, "R1 prio reset");
    exp_rd(A_CTL,  32'h0, "R1 ctl reset");
    exp_req(1'b0, 5'd0,  "R1 req reset");

    // src0=2, src1=3, src2=0, src8=2, src12=1, src13=1
    wr(A_PRIO, 32'h0502000E);
    wr(A_EN, 32'hFFFFFFFF);
    exp_rd(A_EN, 32'h0000FFFF, "R13 enable upper bits");
    wr(A_EN, 32'h0);
    wr(A_CTL, 32'hFFFFFFFE);
    exp_rd(A_CTL, 32'h0, "R13 ctl reserved bits and read-only mask");

    // R2 / R3: edge source while disabled
    src[12] = 1'b1;
    cyc();
    exp_rd(A_FLAG, 32'h1000, "R2 flag latched while disabled");
    exp_req(1'b0, 5'd0, "R6 no request while disabled");
    wr(A_FLAG, 32'h1000);
    exp_rd(A_FLAG, 32'h0, "R3 held-high edge source stays cleared");
    cyc();
    exp_rd(A_FLAG, 32'h0, "R3 still cleared one cycle later");
    src[12] = 1'b0;
    cyc();

    // R4: level source
    src[4] = 1'b1;
    cyc();
    exp_rd(A_FLAG, 32'h10, "R4 level source sets flag");
    wr(A_FLAG, 32'h10);
    exp_rd(A_FLAG, 32'h10, "R4 clear ignored while level high");
    src[4] = 1'b0;
    cyc();
    exp_rd(A_FLAG, 32'h10, "R4 flag kept after drop");
    wr(A_FLAG, 32'h10);
    exp_rd(A_FLAG, 32'h0, "R4 clear after drop");

    // R11: edge in same cycle as clear, multi-clear
    src[12] = 1'b1;
    wr(A_FLAG, 32'h1000);
    src[12] = 1'b0;
    exp_rd(A_FLAG, 32'h1000, "R11 edge wins over clear");
    pulse(13);
    exp_rd(A_FLAG, 32'h3000, "R11 two flags pending");
    wr(A_FLAG, 32'h3000);
    exp_rd(A_FLAG, 32'h0, "R11 two flags cleared in one write");

    // R5 / R6 / R7: enable and tie break
    pulse(12);
    pulse(13);
    wr(A_EN, 32'h3000);
    cyc(2);
    exp_req(1'b0, 5'd0, "R6 no request without global enable");
    wr(A_CTL, 32'h1);
    exp_req(1'b0, 5'd0, "R5 detection cycle before request");
    cyc();
    exp_req(1'b1, 5'd12, "R7 tie at level 1 goes to lowest index");

    // R12 / R8 / R10: hold, ack, preempt
    wr(A_EN, 32'h3002);
    pulse(1);
    cyc();
    exp_req(1'b1, 5'd12, "R12 vector held until acknowledge");
    do_ack();
    exp_req(1'b0, 5'd0, "R5 request drops after acknowledge");
    exp_rd(A_CTL, 32'h201, "R8 level 1 in service");
    exp_rd(A_FLAG, 32'h3002, "R10 software-cleared source keeps flag");
    cyc();
    exp_req(1'b1, 5'd1, "R8 higher level preempts");
    do_ack();
    exp_rd(A_FLAG, 32'h3000, "R10 hardware clear on acknowledge");
    exp_rd(A_CTL, 32'hA01, "R8 levels 1 and 3 in service");
    cyc(2);
    exp_req(1'b0, 5'd0, "R8 lower level blocked");
    wr(A_FLAG, 32'h1000);

    // R9: returns
    do_ret();
    exp_rd(A_CTL, 32'h201, "R9 return pops level 3");
    cyc(2);
    exp_req(1'b0, 5'd0, "R8 equal level stays pending");
    do_ret();
    exp_req(1'b0, 5'd0, "R9 evaluation one cycle after return");
    cyc();
    exp_req(1'b1, 5'd13, "R9 pending request raised after last return");
    do_ack();
    wr(A_FLAG, 32'h2000);
    do_ret();
    exp_rd(A_CTL, 32'h1, "R9 mask empty after return");

    // R7 level beats index; R10 hardware clear on both
    wr(A_EN, 32'h3107);
    src[2] = 1'b1; src[8] = 1'b1;
    cyc();
    src[2] = 1'b0; src[8] = 1'b0;
    cyc();
    exp_req(1'b1, 5'd8, "R7 higher level beats lower index");
    do_ack();
    exp_rd(A_FLAG, 32'h4, "R10 source 8 cleared on acknowledge");
    exp_rd(A_CTL, 32'h401, "R8 level 2 in service");
    cyc();
    exp_req(1'b0, 5'd0, "R8 level 0 blocked by level 2");
    do_ret();
    cyc();
    exp_req(1'b1, 5'd2, "R9 level 0 raised after return");
    do_ack();
    exp_rd(A_FLAG, 32'h0, "R10 source 2 cleared on acknowledge");
    exp_rd(A_CTL, 32'h101, "R8 level 0 in service");
    do_ret();
    exp_rd(A_CTL, 32'h1, "R9 final return");

    // R6: global enable off again
    wr(A_CTL, 32'h0);
    pulse(13);
    cyc(2);
    exp_req(1'b0, 5'd0, "R6 global enable off blocks request");
    exp_rd(A_FLAG, 32'h2000, "R2 flag latched with global enable off");

    report();
  end
endmodule